// File: doc/BRIEF.md
# Single-Ramp Voltmeter Sequencer

This block controls the digital side of a voltage-to-time voltmeter built around one falling analog ramp. A free-running rate divider marks the start of every measurement. At that mark the block clears its decimal counter and sends a one-cycle pulse that restarts the external ramp. It then watches two comparator levels that arrive without any timing relation to the system clock. The first level rises when the ramp crosses the unknown voltage. The second rises when the ramp reaches ground.

Between those two events a counting window is open. Reference-oscillator strobes that arrive while the window is open advance a four-digit BCD counter, so the final count is proportional to the input voltage. When the ground event closes the window, the count is copied into a display register and a one-cycle strobe marks the new reading. A measurement that never sees the ground event before the next rate mark is reported as a timeout, and the display keeps its old value.

Top module: `ramp_dvm_seq`

## Requirements
- R1: A rate mark occurs every DIV = CLK_HZ/RATE_HZ clock cycles, with the first one on the DIV-th edge after reset. The defaults are 100 MHz and 5 measurements per second. Each mark clears `count_o` to zero and sets `ramp_start_o` high for exactly one cycle, starting one edge later.
- R2: After a rate mark, the first rising edge of `cmp_level_i` opens the window. Both comparator inputs pass through a two-flop synchronizer and an edge register, so `gate_o` rises on the third clock edge after the input goes high. A rising edge of `cmp_ground_i` before the window opens is ignored.
- R3: A rising edge of `cmp_ground_i` while the window is open closes it. With `ref_tick_i` held high, the reading equals the number of clock edges between the edge that samples `cmp_level_i` high and the edge that samples `cmp_ground_i` high.
- R4: The counter advances only on edges where the window is open and `ref_tick_i` is 1. With `ref_tick_i` low, the reading is zero.
- R5: Count and display are BCD, four digits. Digit 0 is in bits 3:0 and digit 3 is in bits 15:12. Each digit stays in the range 0 to 9 and carries into the next digit.
- R6: An increment that would pass 9999 leaves the counter at 9999 and sets the overrange flag. That flag is latched with the reading onto `disp_ovr_o`. A reading of exactly 9999 does not set it.
- R7: `disp_o` and `disp_ovr_o` change only on the edge that closes the window. `disp_strobe_o` is high for the one cycle that follows that edge.
- R8: A rate mark that arrives while the block is still waiting for either comparator sets `timeout_o` and leaves the display unchanged. The next latched reading clears `timeout_o`. The first mark after reset never sets it.
- R9: During and after reset, all outputs are zero.
- R10: Once a reading has been latched, further comparator edges have no effect until the next rate mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_level_i | input | 1 | Asynchronous level: ramp has crossed the unknown voltage |
| cmp_ground_i | input | 1 | Asynchronous level: ramp has reached ground |
| ref_tick_i | input | 1 | Reference oscillator strobe, synchronous to clk |
| ramp_start_o | output | 1 | One-cycle pulse that restarts the external ramp |
| gate_o | output | 1 | Counting window open |
| count_o | output | 16 | Live BCD count |
| disp_o | output | 16 | Latched BCD reading |
| disp_ovr_o | output | 1 | Overrange flag latched with the reading |
| disp_strobe_o | output | 1 | New reading latched |
| timeout_o | output | 1 | Last measurement ended without a ground event |

## Verification
The bench measures window lengths of 1, 37, 1234, 9999 and 10000 edges.

- An off-by-one in the synchronizer or in the window bookkeeping would shift every reading by a constant.
- A counter that wraps past 9999 would show a small number without the flag.
- A flag that fires one step early would mark the 9999 case.

The bench also targets the ordering cases:

- A ground pulse before the crossing must not close an unopened window.
- Extra comparator edges after a reading must not produce a second strobe.
- A measurement with no ground event must raise the timeout without disturbing the display.
- A window with the reference strobe held off must read zero.

// File: rtl/dvm_pkg.sv
package dvm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_GATE  = 2'd2,
        PH_HELD  = 2'd3
    } phase_e;

endpackage

// File: rtl/dvm_edge_sync.sv
module dvm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // sh[0..STAGES-1] synchronizer chain, sh[STAGES] previous synced value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // a detected rise lasts one cycle only (R2)
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dvm_rate_timer.sv
module dvm_rate_timer #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int RATE_HZ = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV = CLK_HZ / RATE_HZ;
    localparam int TW  = (DIV > 2) ? $clog2(DIV) : 1;

    logic [TW-1:0] cnt_d, cnt_q;
    logic          at_end;

    always_comb begin
        at_end = (cnt_q == TW'(DIV - 1));
        cnt_d  = at_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = at_end;

    assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dvm_bcd_counter.sv
module dvm_bcd_counter #(
    parameter int DIGITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [4*DIGITS-1:0] cnt_o,
    output logic [4*DIGITS-1:0] nxt_o,
    output logic              ovf_nxt_o
);
    localparam int CW = 4 * DIGITS;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } cnt_t;

    cnt_t          r_d, r_q;
    logic [CW-1:0] inc;
    logic [DIGITS:0] carry;
    logic          all_nine;

    always_comb begin
        carry[0] = 1'b1;
        all_nine = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (r_q.cnt[4*d +: 4] != 4'd9) all_nine = 1'b0;
            if (carry[d]) begin
                if (r_q.cnt[4*d +: 4] == 4'd9) begin
                    inc[4*d +: 4] = 4'd0;
                    carry[d+1]    = 1'b1;
                end else begin
                    inc[4*d +: 4] = r_q.cnt[4*d +: 4] + 4'd1;
                    carry[d+1]    = 1'b0;
                end
            end else begin
                inc[4*d +: 4] = r_q.cnt[4*d +: 4];
                carry[d+1]    = 1'b0;
            end
        end

        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
            r_d.ovf = 1'b0;
        end else if (en_i) begin
            if (all_nine) r_d.ovf = 1'b1;
            else          r_d.cnt = inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt_o     = r_q.cnt;
    assign nxt_o     = r_d.cnt;
    assign ovf_nxt_o = r_d.ovf;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit_chk
            assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                r_q.cnt[4*g +: 4] <= 4'd9);
        end
    endgenerate

    assert_hold_when_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(r_q.cnt));

    assert_freeze_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovf |-> (r_q.cnt == {DIGITS{4'd9}}));

endmodule

// File: rtl/ramp_dvm_seq.sv
module ramp_dvm_seq
    import dvm_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int RATE_HZ     = 5,
    parameter int DIGITS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_level_i,
    input  logic                cmp_ground_i,
    input  logic                ref_tick_i,
    output logic                ramp_start_o,
    output logic                gate_o,
    output logic [4*DIGITS-1:0] count_o,
    output logic [4*DIGITS-1:0] disp_o,
    output logic                disp_ovr_o,
    output logic                disp_strobe_o,
    output logic                timeout_o
);
    localparam int CW = 4 * DIGITS;

    typedef struct packed {
        phase_e        phase;
        logic          ramp_start;
        logic          strobe;
        logic          timeout;
        logic          disp_ovr;
        logic [CW-1:0] disp;
    } ctrl_t;

    ctrl_t         r_d, r_q;
    logic          tick, start_rise, stop_rise;
    logic          cnt_clr, cnt_en, ovf_nxt;
    logic [CW-1:0] cnt_live, cnt_nxt;

    dvm_rate_timer #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    dvm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_level (
        .clk(clk), .rst_n(rst_n), .async_i(cmp_level_i), .rise_o(start_rise));

    dvm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ground (
        .clk(clk), .rst_n(rst_n), .async_i(cmp_ground_i), .rise_o(stop_rise));

    dvm_bcd_counter #(.DIGITS(DIGITS)) u_count (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en),
        .cnt_o(cnt_live), .nxt_o(cnt_nxt), .ovf_nxt_o(ovf_nxt));

    always_comb begin
        r_d            = r_q;
        r_d.ramp_start = 1'b0;
        r_d.strobe     = 1'b0;
        cnt_clr        = 1'b0;
        cnt_en         = 1'b0;
        if (tick) begin
            cnt_clr        = 1'b1;
            r_d.ramp_start = 1'b1;
            if (r_q.phase == PH_ARMED || r_q.phase == PH_GATE) r_d.timeout = 1'b1;
            r_d.phase      = PH_ARMED;
        end else begin
            unique case (r_q.phase)
                PH_ARMED: if (start_rise) r_d.phase = PH_GATE;
                PH_GATE: begin
                    cnt_en = ref_tick_i;
                    if (stop_rise) begin
                        r_d.phase    = PH_HELD;
                        r_d.disp     = cnt_nxt;
                        r_d.disp_ovr = ovf_nxt;
                        r_d.strobe   = 1'b1;
                        r_d.timeout  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ramp_start_o  = r_q.ramp_start;
    assign gate_o        = (r_q.phase == PH_GATE);
    assign count_o       = cnt_live;
    assign disp_o        = r_q.disp;
    assign disp_ovr_o    = r_q.disp_ovr;
    assign disp_strobe_o = r_q.strobe;
    assign timeout_o     = r_q.timeout;

    assert_ramp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ramp_start |=> !r_q.ramp_start);

    assert_count_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ramp_start |-> (cnt_live == '0));

    assert_gate_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(start_rise));

    assert_disp_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.strobe |-> $stable(r_q.disp));

    assert_strobe_clears_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.strobe |-> !r_q.timeout);

    assert_held_no_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HELD && !tick) |=> !gate_o);

endmodule

// File: tb/tb_ramp_dvm_seq.sv
module tb_ramp_dvm_seq;
    localparam int CLK_HZ  = 55_000;
    localparam int RATE_HZ = 5;
    localparam int DIV     = CLK_HZ / RATE_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_level = 1'b0;
    logic        cmp_ground = 1'b0;
    logic        ref_tick = 1'b1;
    logic        ramp_start, gate, disp_ovr, disp_strobe, timeout;
    logic [15:0] count, disp;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int last_ramp = -1;
    bit done = 0;
    logic [16:0] expq[$];

    always #5 clk = ~clk;

    ramp_dvm_seq #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_level_i(cmp_level), .cmp_ground_i(cmp_ground),
        .ref_tick_i(ref_tick), .ramp_start_o(ramp_start), .gate_o(gate), .count_o(count),
        .disp_o(disp), .disp_ovr_o(disp_ovr), .disp_strobe_o(disp_strobe), .timeout_o(timeout));

    always @(negedge clk) ncyc++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(int v);
        logic [15:0] b;
        int t = v;
        for (int d = 0; d < 4; d++) begin
            b[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return b;
    endfunction

    // scoreboard monitor: every strobe must match the oldest expected reading
    always @(negedge clk) begin
        if (rst_n && disp_strobe) begin
            if (expq.size() == 0) begin
                check("R10 unexpected reading", 1, 0);
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                check("R3/R5 reading", {16'h0, disp}, {16'h0, e[15:0]});
                check("R6 overrange", {31'h0, disp_ovr}, {31'h0, e[16]});
                check("R8 timeout cleared", {31'h0, timeout}, 0);
            end
        end
    end

    task automatic wait_ramp();
        do @(negedge clk); while (!ramp_start);
        check("R1 count cleared", {16'h0, count}, 0);
        if (last_ramp >= 0) check("R1 period", ncyc - last_ramp, DIV);
        last_ramp = ncyc;
    endtask

    // one measurement: crossing A edges after ramp start, window length L
    task automatic measure(int a, int l, bit has_stop, bit pre_gnd, bit refon, bit retrig);
        int eff;
        wait_ramp();
        ref_tick = refon;
        if (pre_gnd) begin
            cmp_ground = 1'b1;
            repeat (3) @(negedge clk);
            cmp_ground = 1'b0;
            repeat (3) @(negedge clk);
            check("R2 ground ignored before crossing", {31'h0, gate}, 0);
        end
        repeat (a) @(negedge clk);
        cmp_level = 1'b1;
        if (has_stop) begin
            eff = refon ? l : 0;
            expq.push_back({(eff > 9999), to_bcd(eff > 9999 ? 9999 : eff)});
            if (l > 4) begin
                repeat (3) @(negedge clk);
                check("R2 gate open", {31'h0, gate}, 1);
                repeat (l - 3) @(negedge clk);
            end else begin
                repeat (l) @(negedge clk);
            end
            cmp_ground = 1'b1;
            repeat (6) @(negedge clk);
            check("R3 gate closed", {31'h0, gate}, 0);
            if (retrig) begin
                cmp_level = 1'b0; cmp_ground = 1'b0;
                repeat (4) @(negedge clk);
                cmp_level = 1'b1;
                repeat (4) @(negedge clk);
                cmp_ground = 1'b1;
                repeat (6) @(negedge clk);
                check("R10 no reopen", {31'h0, gate}, 0);
            end
        end
        repeat (2) @(negedge clk);
        cmp_level = 1'b0;
        cmp_ground = 1'b0;
        ref_tick = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R9: reset state
        check("R9 ramp_start", {31'h0, ramp_start}, 0);
        check("R9 gate", {31'h0, gate}, 0);
        check("R9 count", {16'h0, count}, 0);
        check("R9 disp", {16'h0, disp}, 0);
        check("R9 flags", {29'h0, disp_ovr, disp_strobe, timeout}, 0);
        rst_n = 1'b1;
        measure(20, 37, 1, 0, 1, 1);                  // R3 R10
        check("R8 first mark no timeout", {31'h0, timeout}, 0);
        measure(15, 1234, 1, 0, 1, 0);                // R5 carries
        measure(20, 9999, 1, 0, 1, 0);                // R6 boundary, no flag
        measure(20, 10000, 1, 0, 1, 0);               // R6 saturation
        measure(30, 0, 0, 0, 1, 0);                   // no ground event
        wait_ramp();
        check("R8 timeout set", {31'h0, timeout}, 1);
        check("R7 display kept", {16'h0, disp}, 32'h9999);
        check("R7 flag kept", {31'h0, disp_ovr}, 1);
        last_ramp = -1;
        measure(25, 250, 1, 1, 1, 0);                 // R2 early ground
        measure(10, 50, 1, 0, 0, 0);                  // R4 reference off
        measure(12, 1, 1, 0, 1, 0);                   // R3 shortest window
        wait_ramp();
        check("R8 timeout after good reading", {31'h0, timeout}, 0);
        check("R7 all readings seen", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule